// File: doc/BRIEF.md
# Resistive Touch Scan Sequencer

This block runs the measurement loop of a four-wire resistive touch panel. It owns a 16-bit panel control word that chooses which plate terminals are driven to supply or to ground, and which measurement mode the panel front end is in. It also owns a 16-bit converter control word that enables the ADC, picks its input channel and starts conversions. It waits for the converter's valid flag, then keeps the low ten bits of the result. One scan reads the X position, then the Y position, then the pressure. After the scan the panel goes back to pen-detect mode. The block then decides from the panel's two low-detect flags whether the pen is still down.

While the pen stays down, the block emits one sample event carrying X, Y and pressure, and scans again after a gap. When the pen lifts, it emits one release event, but only if the previous scan had produced a sample. It then parks in pen-detect mode until a pen interrupt arrives. A level stop request shuts the loop down. The settle times and the gap are counted in microseconds, using a one-cycle tick supplied from outside.

Top module: `touch_scan_seq`

## Requirements
- R1: After reset, panel_ctl and adc_ctl are 0 and no event strobe is high; with run low the block stays in that state.
- R2: Control word fields: bits 3:0 power -X,+X,-Y,+Y, bits 7:4 ground -X,+X,-Y,+Y, bits 9:8 mode (0 pen-detect, 1 pressure, 2 position), bit 11 bias. A scan drives exactly 0x912, 0xA12, 0x948, 0xA48, 0x9C3, then 0x0C3. Position mode is always entered from pressure mode with the same plate bits.
- R3: A position conversion starts no earlier than POS_SETTLE_US ticks after the position-mode word appears. A pressure conversion starts no earlier than PRS_SETTLE_US ticks after word 0x9C3 appears.
- R4: adc_ctl fields: bit 15 enable, bits 4:2 channel (0 +X, 1 -X, 2 +Y, 3 -Y), bit 7 start, bit 0 sync. Each conversion first writes enable plus channel, then adds start. Bit 0 is set in both words exactly when adc_sync is high.
- R5: A conversion ends when adc_data bit 15 is 1, and the result is adc_data[9:0] only. X is converted on +Y, Y on +X and pressure on +Y.
- R6: adc_ctl holds enable for the whole scan and is 0 once the scan has finished.
- R7: After a scan, the block holds 0x0C3 for GAP_US ticks before it samples plate_lo.
- R8: If plate_lo is 0, one sample event carries X, Y and pressure. The next scan starts after another GAP_US ticks.
- R9: If either plate_lo bit is 1, one release event is emitted only when the previous judgement produced a sample. The block then holds 0x0C3 with no conversions until pen_irq.
- R10: While stop_req is high in a wait state, the block emits a release event if a sample is outstanding. It then drives panel_ctl and adc_ctl to 0 and stays there until run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| run | input | 1 | Starts the loop from the off state |
| stop_req | input | 1 | Level request to end the loop |
| pen_irq | input | 1 | Pen-down interrupt, wakes the idle loop |
| adc_sync | input | 1 | Sets the sync bit in conversion commands |
| plate_lo | input | 2 | Low-detect flags of +X (bit 0) and -X (bit 1) |
| adc_data | input | 16 | Converter data, bit 15 valid |
| panel_ctl | output | 16 | Panel drive and mode word |
| adc_ctl | output | 16 | Converter control word |
| evt_sample | output | 1 | One-cycle sample event strobe |
| evt_release | output | 1 | One-cycle pen-release event strobe |
| evt_x | output | SMP_W | X value of the sample event |
| evt_y | output | SMP_W | Y value of the sample event |
| evt_p | output | SMP_W | Pressure value of the sample event |

## Verification
The bench logs every change of both control words and compares them with the exact scan order. A design that skips the pressure-mode preload, or that swaps the channels for X and Y, would show a wrong word or swapped values. The converter model puts junk in data bits 14:10 and holds valid low for a few cycles. A sequencer that forgets to mask or to wait would report wrong samples. The bench counts ticks across each settle window and each gap, which catches an off-by-many timer. It also covers the release rules: a lift after samples, a lift with nothing outstanding, a stop with a sample outstanding and a stop from idle. A design that emits a spurious release or a missing release is caught by the event counts.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam logic [3:0] PL_MX = 4'b0001;
  localparam logic [3:0] PL_PX = 4'b0010;
  localparam logic [3:0] PL_MY = 4'b0100;
  localparam logic [3:0] PL_PY = 4'b1000;

  typedef enum logic [1:0] {
    MODE_DETECT = 2'd0,
    MODE_PRESS  = 2'd1,
    MODE_POS    = 2'd2
  } mode_e;

  localparam logic [2:0] CH_PX = 3'd0;
  localparam logic [2:0] CH_PY = 3'd2;

  localparam logic [15:0] ADC_EN      = 16'h8000;
  localparam int          ADC_GO_B    = 7;
  localparam int          ADC_VALID_B = 15;
  localparam int          ADC_CH_LSB  = 2;

  typedef enum logic [4:0] {
    S_OFF, S_XPRE, S_XSET, S_XCNV, S_YPRE, S_YSET, S_YCNV,
    S_PSET, S_PCNV, S_GAP1, S_JUDGE, S_GAP2, S_IDLE, S_STOP
  } scan_e;

  function automatic logic [15:0] ctl_word(input logic [3:0] pow, input logic [3:0] gnd,
                                           input mode_e m, input logic bias);
    ctl_word = {4'b0000, bias, 1'b0, m, gnd, pow};
  endfunction
endpackage

// File: rtl/tsc_us_timer.sv
module tsc_us_timer #(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  output logic             done
);
  logic [DLY_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (tick && cnt != 0) cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // R3: an expired window never wraps back into a long wait
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt == '0) |=> cnt == '0);
endmodule

// File: rtl/tsc_adc_seq.sv
module tsc_adc_seq import tsc_pkg::*; #(
  parameter int SMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adc_on,
  input  logic             go,
  input  logic [2:0]       ch,
  input  logic             sync,
  input  logic [15:0]      adc_data,
  output logic [15:0]      adc_ctl,
  output logic             done,
  output logic [SMP_W-1:0] result
);
  typedef enum logic [1:0] {A_IDLE, A_ARM, A_WAIT} adc_st_e;
  adc_st_e st;
  logic    adc_unused;

  assign adc_unused = ^adc_data[ADC_VALID_B-1:SMP_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= A_IDLE;
      adc_ctl <= '0;
      done    <= 1'b0;
      result  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        A_IDLE:
          if (go) begin
            adc_ctl <= ADC_EN | (16'(ch) << ADC_CH_LSB) | {15'b0, sync};
            st      <= A_ARM;
          end else begin
            adc_ctl <= adc_on ? ADC_EN : '0;
          end
        A_ARM: begin
          adc_ctl[ADC_GO_B] <= 1'b1;
          st                <= A_WAIT;
        end
        A_WAIT:
          if (adc_data[ADC_VALID_B]) begin
            result  <= adc_data[SMP_W-1:0];
            done    <= 1'b1;
            adc_ctl <= ADC_EN;
            st      <= A_IDLE;
          end
        default: st <= A_IDLE;
      endcase
    end
  end

  // R4: start is only ever given with the converter enabled
  a_r4_start_needs_en: assert property (@(posedge clk) disable iff (rst)
    adc_ctl[ADC_GO_B] |-> adc_ctl[15]);
  // R4: start rises on top of an enable+channel word written the cycle before
  a_r4_arm_first: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_ctl[ADC_GO_B]) |-> ($past(adc_ctl[15]) && $past(adc_ctl[4:2]) == adc_ctl[4:2]));
  // R5: start is held until the converter reports a valid result
  a_r5_hold_start: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_ctl[ADC_GO_B]) |-> $past(adc_data[ADC_VALID_B]));
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq import tsc_pkg::*; #(
  parameter int SMP_W         = 10,
  parameter int DLY_W         = 16,
  parameter int POS_SETTLE_US = 55,
  parameter int PRS_SETTLE_US = 0,
  parameter int GAP_US        = 10000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             us_tick,
  input  logic             run,
  input  logic             stop_req,
  input  logic             pen_irq,
  input  logic             adc_sync,
  input  logic [1:0]       plate_lo,
  input  logic [15:0]      adc_data,
  output logic [15:0]      panel_ctl,
  output logic [15:0]      adc_ctl,
  output logic             evt_sample,
  output logic             evt_release,
  output logic [SMP_W-1:0] evt_x,
  output logic [SMP_W-1:0] evt_y,
  output logic [SMP_W-1:0] evt_p
);
  localparam logic [15:0] W_XPRE = ctl_word(PL_PX, PL_MX, MODE_PRESS, 1'b1);
  localparam logic [15:0] W_XPOS = ctl_word(PL_PX, PL_MX, MODE_POS, 1'b1);
  localparam logic [15:0] W_YPRE = ctl_word(PL_PY, PL_MY, MODE_PRESS, 1'b1);
  localparam logic [15:0] W_YPOS = ctl_word(PL_PY, PL_MY, MODE_POS, 1'b1);
  localparam logic [15:0] W_PRS  = ctl_word(PL_MX | PL_PX, PL_MY | PL_PY, MODE_PRESS, 1'b1);
  localparam logic [15:0] W_DET  = ctl_word(PL_MX | PL_PX, PL_MY | PL_PY, MODE_DETECT, 1'b0);
  localparam logic [DLY_W-1:0] D_POS = DLY_W'(POS_SETTLE_US);
  localparam logic [DLY_W-1:0] D_PRS = DLY_W'(PRS_SETTLE_US);
  localparam logic [DLY_W-1:0] D_GAP = DLY_W'(GAP_US);

  scan_e            state;
  logic             tmr_load, tmr_done, cnv_go, cnv_done, adc_on, had_smp;
  logic [DLY_W-1:0] tmr_val;
  logic [2:0]       cnv_ch;
  logic [SMP_W-1:0] cnv_res, x_q, y_q;

  tsc_us_timer #(.DLY_W(DLY_W)) u_timer (
    .clk(clk), .rst(rst), .tick(us_tick), .load(tmr_load),
    .load_val(tmr_val), .done(tmr_done));

  tsc_adc_seq #(.SMP_W(SMP_W)) u_adc (
    .clk(clk), .rst(rst), .adc_on(adc_on), .go(cnv_go), .ch(cnv_ch),
    .sync(adc_sync), .adc_data(adc_data), .adc_ctl(adc_ctl),
    .done(cnv_done), .result(cnv_res));

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = D_GAP;
    cnv_go   = 1'b0;
    cnv_ch   = CH_PY;
    case (state)
      S_XPRE, S_YPRE: begin tmr_load = 1'b1; tmr_val = D_POS; end
      S_XSET:  cnv_go = tmr_done;
      S_YSET:  begin cnv_go = tmr_done; cnv_ch = CH_PX; end
      S_PSET:  cnv_go = tmr_done;
      S_YCNV:  begin tmr_load = cnv_done; tmr_val = D_PRS; end
      S_PCNV:  tmr_load = cnv_done;
      S_JUDGE: tmr_load = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_OFF;
      panel_ctl   <= '0;
      adc_on      <= 1'b0;
      had_smp     <= 1'b0;
      evt_sample  <= 1'b0;
      evt_release <= 1'b0;
      evt_x       <= '0;
      evt_y       <= '0;
      evt_p       <= '0;
      x_q         <= '0;
      y_q         <= '0;
    end else begin
      evt_sample  <= 1'b0;
      evt_release <= 1'b0;
      case (state)
        S_OFF:
          if (run && !stop_req) begin
            state <= S_XPRE; panel_ctl <= W_XPRE; adc_on <= 1'b1;
          end
        S_XPRE: begin state <= S_XSET; panel_ctl <= W_XPOS; end
        S_XSET: if (tmr_done) state <= S_XCNV;
        S_XCNV:
          if (cnv_done) begin
            x_q <= cnv_res; state <= S_YPRE; panel_ctl <= W_YPRE;
          end
        S_YPRE: begin state <= S_YSET; panel_ctl <= W_YPOS; end
        S_YSET: if (tmr_done) state <= S_YCNV;
        S_YCNV:
          if (cnv_done) begin
            y_q <= cnv_res; state <= S_PSET; panel_ctl <= W_PRS;
          end
        S_PSET: if (tmr_done) state <= S_PCNV;
        S_PCNV:
          if (cnv_done) begin
            evt_p <= cnv_res; adc_on <= 1'b0; panel_ctl <= W_DET; state <= S_GAP1;
          end
        S_GAP1:
          if (stop_req)      state <= S_STOP;
          else if (tmr_done) state <= S_JUDGE;
        S_JUDGE:
          if (|plate_lo) begin
            evt_release <= had_smp; had_smp <= 1'b0; state <= S_IDLE;
          end else begin
            evt_sample <= 1'b1; had_smp <= 1'b1;
            evt_x <= x_q; evt_y <= y_q; state <= S_GAP2;
          end
        S_GAP2:
          if (stop_req) state <= S_STOP;
          else if (tmr_done) begin
            state <= S_XPRE; panel_ctl <= W_XPRE; adc_on <= 1'b1;
          end
        S_IDLE:
          if (stop_req) state <= S_STOP;
          else if (pen_irq) begin
            state <= S_XPRE; panel_ctl <= W_XPRE; adc_on <= 1'b1;
          end
        S_STOP: begin
          evt_release <= had_smp; had_smp <= 1'b0;
          panel_ctl <= '0; adc_on <= 1'b0; state <= S_OFF;
        end
        default: state <= S_OFF;
      endcase
    end
  end

  // R2: position mode is reached only from pressure mode with unchanged plate drive
  a_r2_pos_after_pres: assert property (@(posedge clk) disable iff (rst)
    (panel_ctl[9:8] == 2'b10 && $past(panel_ctl[9:8]) != 2'b10)
      |-> ($past(panel_ctl) == {panel_ctl[15:10], 2'b01, panel_ctl[7:0]}));
  // R6: no conversion is started while the panel sits in pen-detect mode
  a_r6_no_cnv_detect: assert property (@(posedge clk) disable iff (rst)
    adc_ctl[ADC_GO_B] |-> panel_ctl[9:8] != 2'b00);
  // R8: a sample and a release never share a cycle
  a_r8_evt_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_sample, evt_release}));
  // R10: the cycle after a stop the panel is released and no sample follows
  a_r10_stop_off: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == S_STOP) |-> (panel_ctl == '0 && !evt_sample));
endmodule

// File: tb/tb_touch_scan_seq.sv
module tb_touch_scan_seq;
  localparam int POS = 12, PRS = 3, GAP = 100, SW = 10;

  logic clk = 0, rst = 1, us_tick = 0, run = 0, stop_req = 0, pen_irq = 0, adc_sync = 0;
  logic [1:0]  plate_lo = 2'b00;
  logic [15:0] adc_data = '0;
  logic [15:0] panel_ctl, adc_ctl;
  logic        evt_sample, evt_release;
  logic [SW-1:0] evt_x, evt_y, evt_p;

  touch_scan_seq #(.SMP_W(SW), .DLY_W(16), .POS_SETTLE_US(POS),
                   .PRS_SETTLE_US(PRS), .GAP_US(GAP)) dut (
    .clk(clk), .rst(rst), .us_tick(us_tick), .run(run), .stop_req(stop_req),
    .pen_irq(pen_irq), .adc_sync(adc_sync), .plate_lo(plate_lo), .adc_data(adc_data),
    .panel_ctl(panel_ctl), .adc_ctl(adc_ctl), .evt_sample(evt_sample),
    .evt_release(evt_release), .evt_x(evt_x), .evt_y(evt_y), .evt_p(evt_p));

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int n_smp = 0, n_rel = 0;
  int lx = 0, ly = 0, lp = 0;
  int pan_log [32];
  int adc_log [32];
  int pan_n = 0, adc_n = 0;
  logic [15:0] prev_pan = '0, prev_adc = '0;
  int gap_cnt = 0, gap1 = 0, gap2 = 0, xs_cnt = 0, ps_cnt = 0;
  bit seen_sync = 0, seen_nosync = 0;
  logic [SW-1:0] x_val = '0, y_val = '0, p_val = '0;

  // microsecond tick: one cycle high, one low
  initial forever begin
    @(posedge clk); #1;
    us_tick = ~us_tick;
  end

  // converter model: valid appears 4 cycles after start, junk in bits 14:10
  initial begin
    int acnt;
    acnt = 0;
    forever begin
      @(posedge clk); #1;
      if (adc_ctl[7]) begin
        if (acnt < 3) acnt++;
        else if (panel_ctl[9:8] == 2'b01) adc_data = {1'b1, 5'b10110, p_val};
        else if (adc_ctl[4:2] == 3'd2)    adc_data = {1'b1, 5'b10110, x_val};
        else if (adc_ctl[4:2] == 3'd0)    adc_data = {1'b1, 5'b10110, y_val};
        else                              adc_data = {1'b1, 5'b10110, 10'h3FF};
      end else begin
        acnt = 0;
        adc_data = '0;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (evt_sample) begin
        n_smp++; lx = evt_x; ly = evt_y; lp = evt_p;
        gap1 = gap_cnt; gap_cnt = 0;
      end
      if (evt_release) n_rel++;
      if (panel_ctl != prev_pan) begin
        if (pan_n < 32) pan_log[pan_n] = panel_ctl;
        pan_n++;
        if (prev_pan == 16'h00C3) gap2 = gap_cnt;
        gap_cnt = us_tick ? 1 : 0;
        if (panel_ctl == 16'h0A12) xs_cnt = us_tick ? 1 : 0;
        if (panel_ctl == 16'h09C3) ps_cnt = us_tick ? 1 : 0;
        prev_pan = panel_ctl;
      end else if (us_tick) begin
        gap_cnt++;
        if (panel_ctl == 16'h0A12 && !adc_ctl[7]) xs_cnt++;
        if (panel_ctl == 16'h09C3 && !adc_ctl[7]) ps_cnt++;
      end
      if (adc_ctl != prev_adc) begin
        if (adc_n < 32) adc_log[adc_n] = adc_ctl;
        adc_n++;
        prev_adc = adc_ctl;
      end
      if (adc_ctl[7] && adc_ctl[0])  seen_sync = 1;
      if (adc_ctl[7] && !adc_ctl[0]) seen_nosync = 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_logs();
    pan_n = 0; adc_n = 0; seen_sync = 0; seen_nosync = 0;
  endtask

  task automatic wait_smp(input int tgt);
    for (int i = 0; i < 6000 && n_smp < tgt; i++) @(negedge clk);
  endtask

  task automatic wait_rel(input int tgt);
    for (int i = 0; i < 6000 && n_rel < tgt; i++) @(negedge clk);
  endtask

  task automatic wait_pan(input logic [15:0] v);
    for (int i = 0; i < 6000 && panel_ctl != v; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic sig);
    @(negedge clk); sig = 1;
    @(negedge clk); sig = 0;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(panel_ctl == 0, "R1 panel_ctl after reset", panel_ctl, 0);
    chk(adc_ctl == 0, "R1 adc_ctl after reset", adc_ctl, 0);
    chk(!evt_sample && !evt_release, "R1 events after reset", {evt_sample, evt_release}, 0);
    repeat (30) @(negedge clk);
    chk(panel_ctl == 0 && adc_ctl == 0, "R1 stays off without run", panel_ctl, 0);
  endtask

  task automatic t_first_scan();
    int exp_pan [6] = '{16'h0912, 16'h0A12, 16'h0948, 16'h0A48, 16'h09C3, 16'h00C3};
    int exp_adc [10] = '{16'h8000, 16'h8008, 16'h8088, 16'h8000, 16'h8080,
                         16'h8000, 16'h8008, 16'h8088, 16'h8000, 16'h0000};
    x_val = 10'h155; y_val = 10'h2AA; p_val = 10'h0F0; plate_lo = 2'b00;
    clear_logs();
    pulse(run);
    wait_smp(1);
    chk(n_smp == 1, "R8 first sample event", n_smp, 1);
    chk(lx == 10'h155, "R5 X value from +Y channel", lx, 10'h155);
    chk(ly == 10'h2AA, "R5 Y value from +X channel", ly, 10'h2AA);
    chk(lp == 10'h0F0, "R5 pressure value", lp, 10'h0F0);
    chk(pan_n == 6, "R2 number of panel words", pan_n, 6);
    for (int i = 0; i < 6; i++)
      chk(pan_log[i] == exp_pan[i], "R2 panel word order", pan_log[i], exp_pan[i]);
    chk(adc_n == 10, "R4 number of converter words", adc_n, 10);
    for (int i = 0; i < 10; i++)
      chk(adc_log[i] == exp_adc[i], "R4 R6 converter word order", adc_log[i], exp_adc[i]);
    chk(!seen_sync && seen_nosync, "R4 sync bit clear when adc_sync low", seen_sync, 0);
    chk(xs_cnt >= POS && xs_cnt <= POS + 2, "R3 position settle ticks", xs_cnt, POS);
    chk(ps_cnt >= PRS && ps_cnt <= PRS + 2, "R3 pressure settle ticks", ps_cnt, PRS);
    chk(gap1 >= GAP && gap1 <= GAP + 2, "R7 gap before pen check", gap1, GAP);
    chk(adc_ctl == 0, "R6 converter off after scan", adc_ctl, 0);
    chk(panel_ctl == 16'h00C3, "R7 pen-detect word after scan", panel_ctl, 16'h00C3);
  endtask

  task automatic t_rescan();
    x_val = 10'h001; y_val = 10'h3FE; p_val = 10'h200;
    wait_smp(2);
    chk(n_smp == 2, "R8 rescan sample event", n_smp, 2);
    chk(gap2 >= GAP && gap2 <= GAP + 2, "R8 gap before rescan", gap2, GAP);
    chk(lx == 10'h001 && ly == 10'h3FE, "R5 rescan X/Y masked", {lx, ly}, {10'h001, 10'h3FE});
    chk(lp == 10'h200, "R5 rescan pressure", lp, 10'h200);
    chk(n_rel == 0, "R9 no release while pen down", n_rel, 0);
  endtask

  task automatic t_lift();
    int s0;
    s0 = n_smp;
    plate_lo = 2'b01;
    wait_rel(1);
    chk(n_rel == 1, "R9 one release after lift", n_rel, 1);
    repeat (8 * GAP) @(negedge clk);
    chk(n_rel == 1, "R9 release not repeated", n_rel, 1);
    chk(n_smp == s0, "R9 no sample while lifted", n_smp, s0);
    chk(panel_ctl == 16'h00C3 && adc_ctl == 0, "R9 idle in pen-detect", panel_ctl, 16'h00C3);
  endtask

  task automatic t_irq_lifted();
    int s0, r0;
    s0 = n_smp; r0 = n_rel;
    plate_lo = 2'b10;
    clear_logs();
    pulse(pen_irq);
    wait_pan(16'h0A48);
    wait_pan(16'h00C3);
    repeat (4 * GAP + 40) @(negedge clk);
    chk(pan_n == 6, "R9 pen_irq starts a scan", pan_n, 6);
    chk(n_rel == r0, "R9 no release without outstanding sample", n_rel, r0);
    chk(n_smp == s0, "R9 no sample while still lifted", n_smp, s0);
  endtask

  task automatic t_sync();
    int s0;
    s0 = n_smp;
    adc_sync = 1; plate_lo = 2'b00;
    x_val = 10'h0AA; y_val = 10'h333; p_val = 10'h07F;
    clear_logs();
    pulse(pen_irq);
    wait_smp(s0 + 1);
    chk(seen_sync && !seen_nosync, "R4 sync bit set when adc_sync high", seen_sync, 1);
    chk(lx == 10'h0AA && ly == 10'h333 && lp == 10'h07F, "R8 sample with sync", lx, 10'h0AA);
    adc_sync = 0;
  endtask

  task automatic t_stop_active();
    int r0;
    r0 = n_rel;
    @(negedge clk); stop_req = 1;
    wait_pan(16'h0000);
    @(negedge clk);
    chk(n_rel == r0 + 1, "R10 release on stop with outstanding sample", n_rel, r0 + 1);
    chk(panel_ctl == 0 && adc_ctl == 0, "R10 controls zero after stop", panel_ctl, 0);
    stop_req = 0;
    repeat (3 * GAP) @(negedge clk);
    chk(panel_ctl == 0 && adc_ctl == 0, "R10 stays off after stop", panel_ctl, 0);
  endtask

  task automatic t_stop_idle();
    int r0, s0;
    plate_lo = 2'b11;
    r0 = n_rel; s0 = n_smp;
    pulse(run);
    wait_pan(16'h0A48);
    wait_pan(16'h00C3);
    repeat (2 * GAP + 40) @(negedge clk);
    @(negedge clk); stop_req = 1;
    wait_pan(16'h0000);
    repeat (3) @(negedge clk);
    chk(n_rel == r0, "R10 no release on stop from idle", n_rel, r0);
    chk(n_smp == s0, "R9 no sample with both flags set", n_smp, s0);
    chk(panel_ctl == 0, "R10 off after idle stop", panel_ctl, 0);
    stop_req = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_first_scan();
    t_rescan();
    t_lift();
    t_irq_lifted();
    t_sync();
    t_stop_active();
    t_stop_idle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule